// File: doc/BRIEF.md
# Interleaved Reed-Solomon Syndrome Unit

This block computes the sixteen syndromes of an RS(255,239) codeword over 8-bit symbols. The received word streams in on a valid/ready handshake, one symbol per cycle, starting with the highest-index symbol r254 and ending with r0. A single zero symbol is implied ahead of r254, so the word is treated as 256 symbols long. Each syndrome is built from four interleaved partial Horner sums. The accepted symbols go to the four partial sums in rotation, and each partial sum uses the multiplier alpha^(4i). When the last symbol has been taken, the four partials of each syndrome are combined into the final value.

The unit first evaluates syndromes 1 to 8. If all eight are zero, the word is treated as either clean or beyond repair. The unit then raises its done strobe straight away and does not compute the upper eight syndromes. If any of the eight is non-zero, the unit pulses a restart request. An upstream buffer answers by sending the same word again, and on that second pass the unit computes syndromes 9 to 16. A done strobe, an error-present flag and the full syndrome vector are reported together at the end.

Top module: `rs_syndrome_unit`

## Requirements
- R1: After reset, in_ready is 1 and done_o, restart_o and err_o are 0.
- R2: After a word, syndromes_o[8*(i-1) +: 8] holds s_i = XOR over j=0..254 of r_j*alpha^(i*j) for i = 1..8. Symbols arrive in the order r254 first, r0 last.
- R3: If any of s_1..s_8 is non-zero, restart_o is high for exactly one cycle and in_ready is 0 in that cycle. After the word has been sent again, syndromes_o bits [8*(i-1) +: 8] hold s_i for i = 9..16.
- R4: If s_1..s_8 are all zero, no restart is requested, done_o follows the first pass, and the upper eight syndrome fields read 0.
- R5: While done_o is 1, err_o equals the OR of all bits of syndromes_o.
- R6: done_o goes high for exactly one cycle per word, and only after the last pass has ended.
- R7: A symbol counts only in a cycle where in_valid and in_ready are both 1. Idle cycles and values offered while in_ready is 0 have no effect on the result.
- R8: Arithmetic is in GF(2^8) with field polynomial 0x11D and alpha = 0x02. A word whose only non-zero symbol is r1 = 1 gives s_1 = 0x02, s_8 = 0x1D and s_9 = 0x3A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received symbol is offered |
| in_ready | output | 1 | The unit takes a symbol this cycle if in_valid is 1 |
| in_sym | input | 8 | Received symbol, highest index first |
| restart_o | output | 1 | One-cycle request to send the current word again |
| done_o | output | 1 | One-cycle strobe: the syndromes and the error flag are valid |
| err_o | output | 1 | At least one computed syndrome is non-zero |
| syndromes_o | output | 128 | s_i in bits [8*(i-1) +: 8], i = 1..16 |

## Verification
Several words are used, and each one separates a different kind of failure.

- **All-zero word and full generator codeword:** both must finish after one pass with every syndrome zero.
- **Codeword of the degree-8 half generator:** this word is zero at alpha^1..alpha^8 only. It shows whether the early exit really skips the upper syndromes and reports them as zero.
- **Single errors at r0, r1 and r254:** these place one symbol in the last, second-to-last and first stream slot. They expose errors in stream rotation, merge weights and field constants.
- **Pseudo-random words:** these are sent both with and without idle gaps carrying junk data. They check the replay path and show that unaccepted data is ignored.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    localparam int          SYM_W   = 8;
    localparam logic [8:0]  GF_POLY = 9'h11D;
    localparam int          N_SYM   = 255;
    localparam int          NSYN    = 16;
    localparam int          HALF    = NSYN / 2;
    localparam int          NSTREAM = 4;
    localparam int          SEL_W   = $clog2(NSTREAM);
    localparam int          CNT_W   = $clog2(N_SYM);

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        ST_ACCUM,
        ST_MERGE,
        ST_REPLAY,
        ST_FINISH
    } phase_e;

    typedef struct packed {
        logic             accept;
        logic [SEL_W-1:0] stream_sel;
        logic             upper;
        logic             clear_acc;
        logic             merge_en;
        logic             clear_syn;
    } ctl_t;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t p;
        sym_t x;
        p = '0;
        x = a;
        for (int k = 0; k < SYM_W; k++) begin
            if (b[k]) p = p ^ x;
            x = x[SYM_W-1] ? ((x << 1) ^ GF_POLY[SYM_W-1:0]) : (x << 1);
        end
        return p;
    endfunction

    function automatic sym_t gf_pow_alpha(int e);
        sym_t r;
        r = sym_t'(1);
        for (int k = 0; k < e; k++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_lane.sv
module rs_syn_lane
    import rs_syn_pkg::*;
#(
    parameter int LANE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             clear,
    input  logic             upper,
    input  logic [SEL_W-1:0] sel,
    input  sym_t             sym,
    output sym_t             merged_o
);
    localparam int   E_LO = LANE;
    localparam int   E_HI = LANE + HALF;
    localparam sym_t LO1  = gf_pow_alpha(E_LO);
    localparam sym_t LO2  = gf_pow_alpha(2 * E_LO);
    localparam sym_t LO3  = gf_pow_alpha(3 * E_LO);
    localparam sym_t LO4  = gf_pow_alpha(NSTREAM * E_LO);
    localparam sym_t HI1  = gf_pow_alpha(E_HI);
    localparam sym_t HI2  = gf_pow_alpha(2 * E_HI);
    localparam sym_t HI3  = gf_pow_alpha(3 * E_HI);
    localparam sym_t HI4  = gf_pow_alpha(NSTREAM * E_HI);

    logic [NSTREAM-1:0][SYM_W-1:0] part_q;
    sym_t step, w1, w2, w3;

    always_comb begin
        step = upper ? HI4 : LO4;
        w1   = upper ? HI1 : LO1;
        w2   = upper ? HI2 : LO2;
        w3   = upper ? HI3 : LO3;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            part_q <= '0;
        end else if (accept) begin
            part_q[sel] <= gf_mul(part_q[sel], step) ^ sym;
        end
    end

    // stream 0 carries the highest weight, stream 3 the unit weight
    assign merged_o = gf_mul(part_q[0], w3) ^ gf_mul(part_q[1], w2)
                    ^ gf_mul(part_q[2], w1) ^ part_q[3];

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clear) |=> $stable(part_q));

endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
    import rs_syn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic any_nz,
    output ctl_t ctl_o,
    output logic in_ready,
    output logic restart_o,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SYM - 1);

    phase_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             upper_q;
    logic             take;

    assign in_ready  = (st_q == ST_ACCUM);
    assign take      = in_valid && in_ready;
    assign restart_o = (st_q == ST_REPLAY);
    assign done_o    = (st_q == ST_FINISH);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_ACCUM:  if (take && cnt_q == LAST) st_d = ST_MERGE;
            ST_MERGE:  st_d = (!upper_q && any_nz) ? ST_REPLAY : ST_FINISH;
            ST_REPLAY: st_d = ST_ACCUM;
            ST_FINISH: st_d = ST_ACCUM;
            default:   st_d = ST_ACCUM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_ACCUM;
            cnt_q   <= '0;
            upper_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (st_q == ST_REPLAY) upper_q <= 1'b1;
            if (st_q == ST_FINISH) upper_q <= 1'b0;
        end
    end

    always_comb begin
        ctl_o.accept     = take;
        // the implied pad symbol occupies stream 0, so the first real symbol goes to stream 1
        ctl_o.stream_sel = cnt_q[SEL_W-1:0] + SEL_W'(1);
        ctl_o.upper      = upper_q;
        ctl_o.clear_acc  = (st_q == ST_REPLAY) || (st_q == ST_FINISH);
        ctl_o.merge_en   = (st_q == ST_MERGE);
        ctl_o.clear_syn  = (st_q == ST_FINISH);
    end

    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    assert_restart_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/rs_syndrome_unit.sv
module rs_syndrome_unit
    import rs_syn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [SYM_W-1:0]      in_sym,
    output logic                  restart_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic [NSYN*SYM_W-1:0] syndromes_o
);
    ctl_t ctl;
    sym_t merged [HALF];
    sym_t syn_q  [NSYN];
    logic any_nz;
    logic err_q;

    rs_syn_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .any_nz    (any_nz),
        .ctl_o     (ctl),
        .in_ready  (in_ready),
        .restart_o (restart_o),
        .done_o    (done_o)
    );

    for (genvar l = 0; l < HALF; l++) begin : g_lane
        rs_syn_lane #(.LANE(l + 1)) i_lane (
            .clk      (clk),
            .rst      (rst),
            .accept   (ctl.accept),
            .clear    (ctl.clear_acc),
            .upper    (ctl.upper),
            .sel      (ctl.stream_sel),
            .sym      (in_sym),
            .merged_o (merged[l])
        );
    end

    always_comb begin
        any_nz = 1'b0;
        for (int l = 0; l < HALF; l++) any_nz = any_nz | (|merged[l]);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear_syn) begin
            for (int i = 0; i < NSYN; i++) syn_q[i] <= '0;
            err_q <= 1'b0;
        end else if (ctl.merge_en) begin
            for (int l = 0; l < HALF; l++) begin
                if (ctl.upper) syn_q[HALF + l] <= merged[l];
                else           syn_q[l]        <= merged[l];
            end
            err_q <= (ctl.upper ? err_q : 1'b0) | any_nz;
        end
    end

    for (genvar i = 0; i < NSYN; i++) begin : g_out
        assign syndromes_o[i*SYM_W +: SYM_W] = syn_q[i];
    end

    assign err_o = err_q;

    assert_err_flag_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o == (|syndromes_o)));
    assert_skip_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (syndromes_o[NSYN*SYM_W-1:HALF*SYM_W] == '0));
    assert_replay_cause_R3: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> (syndromes_o[HALF*SYM_W-1:0] != '0));
    assert_busy_no_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (restart_o || done_o) |-> !in_ready);

endmodule

// File: tb/test_rs_syndrome_unit.sv
module test_rs_syndrome_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [7:0]   in_sym;
    logic         restart_o;
    logic         done_o;
    logic         err_o;
    logic [127:0] syndromes_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] word  [255];
    logic [7:0] ref_s [16];
    logic [7:0] gpoly [17];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    rs_syndrome_unit i_rs_syndrome_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sym(in_sym), .restart_o(restart_o), .done_o(done_o),
        .err_o(err_o), .syndromes_o(syndromes_o)
    );

    function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] bpow(int e);
        logic [7:0] r = 8'h01;
        for (int k = 0; k < e; k++) r = bmul(r, 8'h02);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compute_ref();
        for (int i = 1; i <= 16; i++) begin
            logic [7:0] acc = 8'h00;
            logic [7:0] x   = 8'h01;
            logic [7:0] ai  = bpow(i);
            for (int j = 0; j < 255; j++) begin
                acc ^= bmul(word[j], x);
                x = bmul(x, ai);
            end
            ref_s[i-1] = acc;
        end
    endtask

    task automatic clear_word();
        for (int j = 0; j < 255; j++) word[j] = 8'h00;
    endtask

    task automatic build_gen(input int deg);
        for (int k = 0; k < 17; k++) gpoly[k] = 8'h00;
        gpoly[0] = 8'h01;
        for (int i = 1; i <= deg; i++) begin
            logic [7:0] root = bpow(i);
            for (int k = 16; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ bmul(gpoly[k], root);
            gpoly[0] = bmul(gpoly[0], root);
        end
        clear_word();
        for (int k = 0; k <= deg; k++) word[k] = gpoly[k];
    endtask

    task automatic send_pass(input bit stall);
        for (int j = 254; j >= 0; j--) begin
            @(negedge clk);
            if (stall && (j % 3 == 0)) begin
                in_valid = 1'b0;
                in_sym   = 8'hFF;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sym   = word[j];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
    endtask

    task automatic run_word(input string name, input bit stall);
        int   restarts = 0;
        bit   got_done = 0;
        bit   exp_nz   = 0;
        logic [127:0] got = '0;
        logic         got_err = 1'b0;
        compute_ref();
        for (int i = 0; i < 8; i++) if (ref_s[i] != 8'h00) exp_nz = 1;
        send_pass(stall);
        for (int w = 0; w < 40 && !got_done; w++) begin
            @(negedge clk);
            if (restart_o) begin
                in_valid = 1'b0;
                restarts++;
                check(in_ready == 1'b0, "R3", {name, " ready during restart"}, in_ready, 0);
                if (restarts == 1) send_pass(stall);
            end else if (done_o) begin
                in_valid = 1'b0;
                got_done = 1;
                got      = syndromes_o;
                got_err  = err_o;
            end else begin
                in_sym = 8'hA5;   // offered while in_ready is 0 (R7)
            end
        end
        check(restarts == int'(exp_nz), exp_nz ? "R3" : "R4", {name, " restart count"},
              restarts, int'(exp_nz));
        check(got_done, "R6", {name, " done seen"}, got_done, 1);
        for (int i = 0; i < 8; i++)
            check(got[8*i +: 8] == ref_s[i], stall ? "R7" : "R2",
                  $sformatf("%s s%0d", name, i + 1), got[8*i +: 8], ref_s[i]);
        for (int i = 8; i < 16; i++) begin
            logic [7:0] e = exp_nz ? ref_s[i] : 8'h00;
            check(got[8*i +: 8] == e, exp_nz ? "R3" : "R4",
                  $sformatf("%s s%0d", name, i + 1), got[8*i +: 8], e);
        end
        check(got_err == exp_nz, "R5", {name, " err flag"}, got_err, int'(exp_nz));
        @(negedge clk);
        check(done_o == 1'b0, "R6", {name, " done one cycle"}, done_o, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_sym = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1,  "R1", "ready after reset", in_ready, 1);
        check(done_o == 1'b0,    "R1", "done after reset", done_o, 0);
        check(restart_o == 1'b0, "R1", "restart after reset", restart_o, 0);
        check(err_o == 1'b0,     "R1", "err after reset", err_o, 0);
    endtask

    task automatic t_zero();
        clear_word();
        run_word("zero word", 0);
    endtask

    task automatic t_err_r0();
        clear_word();
        word[0] = 8'h5A;
        run_word("error at r0", 0);
    endtask

    task automatic t_field_r1();
        clear_word();
        word[1] = 8'h01;
        compute_ref();
        check(ref_s[0] == 8'h02 && ref_s[7] == 8'h1D && ref_s[8] == 8'h3A,
              "R8", "bench field constants", ref_s[7], 8'h1D);
        run_word("error at r1", 0);
        check(syndromes_o[7:0] == 8'h00, "R6", "syndromes cleared after done",
              syndromes_o[7:0], 0);
    endtask

    task automatic t_field_check();
        logic [127:0] got = '0;
        clear_word();
        word[1] = 8'h01;
        send_pass(0);
        for (int w = 0; w < 40; w++) begin
            @(negedge clk);
            if (restart_o) begin in_valid = 1'b0; send_pass(0); end
            else if (done_o) begin in_valid = 1'b0; got = syndromes_o; break; end
        end
        check(got[7:0]   == 8'h02, "R8", "s1 for r1=1", got[7:0], 8'h02);
        check(got[63:56] == 8'h1D, "R8", "s8 for r1=1", got[63:56], 8'h1D);
        check(got[71:64] == 8'h3A, "R8", "s9 for r1=1", got[71:64], 8'h3A);
    endtask

    task automatic t_err_top();
        clear_word();
        word[254] = 8'h33;
        run_word("error at r254", 0);
    endtask

    task automatic t_full_codeword();
        build_gen(16);
        run_word("full codeword", 0);
    endtask

    task automatic t_half_codeword();
        build_gen(8);
        compute_ref();
        check(ref_s[8] != 8'h00, "R4", "half codeword has upper content", ref_s[8], 1);
        run_word("half codeword", 0);
    endtask

    task automatic t_random(input bit stall);
        for (int j = 0; j < 255; j++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            word[j] = lfsr[7:0] ^ lfsr[15:8];
        end
        run_word(stall ? "random stalled" : "random", stall);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_zero();
        t_err_r0();
        t_field_r1();
        t_field_check();
        t_err_top();
        t_full_codeword();
        t_half_codeword();
        t_random(0);
        t_random(1);
        t_random(1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule